// File: doc/BRIEF.md
# Token-chained readout serializer

Each front-end chip in a readout chain holds a small store of digital words and shares two lines with the acquisition system: one serial data line and one transmit-active flag. Only one chip may drive these lines at a time. The block described here is the per-chip controller that decides when this chip drives them. It stays released while idle. A start token from the previous chip wakes it. It then reads its stored words through a synchronous memory read port and shifts them onto the data line with the transmit flag raised. When the last bit has gone out, it emits a single-cycle end token, which is wired to the next chip's start input.

The readout runs between acquisition bursts, after conversion is complete, on a slow readout clock of a few MHz. Shifting is continuous: the next word is fetched during the current word, so there are no idle cycles between words. The number of words to send is sampled from `word_count` when the token arrives. It must not exceed the memory depth. `WORD_W` must be at least 2.

Top module: `rdchain_node`

## Requirements
- R1: While reset is low, and immediately when it is asserted mid-readout, `ser_data_oe`, `xmit_oe`, `ser_data`, `xmit_flag`, `end_tok` and `mem_rd_en` are all 0.
- R2: Outside its own stream, the chip keeps both enables at 0 and drives `ser_data` and `xmit_flag` at 0. At most one chip in a chain has its enables high in any cycle.
- R3: When `start_tok` (active high) is seen in IDLE with a non-zero count, the read of address 0 is issued in the next cycle. The first data bit appears on the line in the third cycle after the token cycle.
- R4: Words are sent in ascending address order starting at 0, each one MSB first, with no gap between words.
- R5: For a count N > 0, `xmit_flag` is high for exactly N·WORD_W consecutive cycles.
- R6: `end_tok` is a single-cycle pulse in the cycle right after the last bit. It occurs exactly once per accepted token.
- R7: When the count sampled at the token is 0, `end_tok` pulses in the cycle right after the token. The flag is never raised and no read is issued.
- R8: A `start_tok` that arrives while the chip is not in IDLE has no effect.
- R9: `word_count` is sampled only when the token is accepted. Later changes do not alter the stream.
- R10: Exactly one read per word is issued, with addresses 0..N-1 in order. Read data is expected one cycle after `mem_rd_en`. The next word is requested in the second-to-last bit cycle of the current word.
- R11: In a chain, each chip's busy time from its token to its end token is N·WORD_W+3 cycles for N > 0, and 1 cycle for N = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_tok | input | 1 | Start token from the previous chip (or from the acquisition system for the first chip) |
| word_count | input | ADDR_W+1 | Number of stored words to send, sampled at the token |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | WORD_W | Memory read data, valid one cycle after the strobe |
| ser_data | output | 1 | Serial data toward the shared line |
| ser_data_oe | output | 1 | Drive enable for the shared data line |
| xmit_flag | output | 1 | Transmit-active flag toward the shared line |
| xmit_oe | output | 1 | Drive enable for the shared flag line |
| end_tok | output | 1 | End token, one cycle, to the next chip's start input |

## Verification
A wrong state register shows at the ports within one cycle. A stray SHIFT raises the enables while another chip owns the lines, which is seen as contention on the shared bus. A stray DONE emits an extra end token that wakes the next chip early. A wrong bit counter or word index moves the falling edge of the flag away from N·WORD_W cycles. It also shifts the position of the end token, which delays or advances every later chip in the chain. A missed prefetch corrupts the first bit of the next word in the cycle where that word starts.

// File: rtl/rdchain_pkg.sv
`timescale 1ns/1ps
package rdchain_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_PRIME = 3'd2,
        ST_SHIFT = 3'd3,
        ST_DONE  = 3'd4
    } rd_state_e;
endpackage

// File: rtl/rdchain_fsm.sv
`timescale 1ns/1ps
module rdchain_fsm
    import rdchain_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tok,
    input  logic [ADDR_W:0]   word_count,
    output rd_state_e         state_o,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              load,
    output logic              shift_en
);
    localparam int BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] PREF_BIT = BIT_W'(WORD_W - 2);
    localparam logic [ADDR_W:0]  ONE_IDX  = (ADDR_W+1)'(1);

    rd_state_e         state_q, state_d;
    logic [ADDR_W:0]   words_q, words_d;
    logic [ADDR_W:0]   widx_q, widx_d;
    logic [ADDR_W:0]   widx_nxt;
    logic [BIT_W-1:0]  bit_q, bit_d;
    logic              last_bit, last_word;

    assign widx_nxt  = widx_q + ONE_IDX;
    assign last_bit  = (bit_q == LAST_BIT);
    assign last_word = (widx_nxt == words_q);
    assign state_o   = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            words_q <= '0;
            widx_q  <= '0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            words_q <= words_d;
            widx_q  <= widx_d;
            bit_q   <= bit_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        words_d = words_q;
        widx_d  = widx_q;
        bit_d   = bit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_tok) begin
                    words_d = word_count;
                    widx_d  = '0;
                    bit_d   = '0;
                    state_d = (word_count == '0) ? ST_DONE : ST_FETCH;
                end
            end
            ST_FETCH: state_d = ST_PRIME;
            ST_PRIME: begin
                bit_d   = '0;
                state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (last_bit) begin
                    bit_d = '0;
                    if (last_word) begin
                        state_d = ST_DONE;
                    end else begin
                        widx_d = widx_nxt;
                    end
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        rd_en    = 1'b0;
        rd_addr  = widx_q[ADDR_W-1:0];
        load     = 1'b0;
        shift_en = 1'b0;
        unique case (state_q)
            ST_FETCH: rd_en = 1'b1;
            ST_PRIME: load  = 1'b1;
            ST_SHIFT: begin
                shift_en = 1'b1;
                if (bit_q == PREF_BIT && !last_word) begin
                    rd_en   = 1'b1;
                    rd_addr = widx_nxt[ADDR_W-1:0];
                end
                if (last_bit && !last_word) begin
                    load = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rdchain_shift.sv
`timescale 1ns/1ps
module rdchain_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift_en,
    input  logic [WORD_W-1:0] din,
    output logic              msb
);
    logic [WORD_W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= din;
        end else if (shift_en) begin
            sr_q <= {sr_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/rdchain_node.sv
`timescale 1ns/1ps
module rdchain_node
    import rdchain_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_tok,
    input  logic [ADDR_W:0]   word_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              ser_data,
    output logic              ser_data_oe,
    output logic              xmit_flag,
    output logic              xmit_oe,
    output logic              end_tok
);
    rd_state_e cur_state;
    logic      load, shift_en, sr_msb;

    rdchain_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_tok  (start_tok),
        .word_count (word_count),
        .state_o    (cur_state),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_rd_addr),
        .load       (load),
        .shift_en   (shift_en)
    );

    rdchain_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift_en (shift_en),
        .din      (mem_rd_data),
        .msb      (sr_msb)
    );

    // line outputs decoded from the state
    always_comb begin
        ser_data    = 1'b0;
        ser_data_oe = 1'b0;
        xmit_flag   = 1'b0;
        xmit_oe     = 1'b0;
        end_tok     = 1'b0;
        unique case (cur_state)
            ST_SHIFT: begin
                ser_data    = sr_msb;
                ser_data_oe = 1'b1;
                xmit_flag   = 1'b1;
                xmit_oe     = 1'b1;
            end
            ST_DONE: end_tok = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rdchain_node_chk.sv
`timescale 1ns/1ps
module rdchain_node_chk
    import rdchain_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_tok,
    input logic [ADDR_W:0]   word_count,
    input rd_state_e         cur_state,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              ser_data,
    input logic              xmit_flag,
    input logic              xmit_oe,
    input logic              end_tok
);
    logic [31:0] run_len, exp_len;
    logic        accept;

    assign accept = (cur_state == ST_IDLE) && start_tok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
            exp_len <= '0;
        end else if (accept) begin
            run_len <= '0;
            exp_len <= 32'(word_count) * 32'(WORD_W);
        end else if (xmit_oe) begin
            run_len <= run_len + 32'd1;
        end
    end

    assert_quiet_when_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_oe |-> (!xmit_flag && !ser_data));

    assert_first_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && word_count != '0) |=> (mem_rd_en && mem_rd_addr == '0));

    assert_run_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xmit_oe) |-> (run_len == exp_len));

    assert_end_after_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xmit_oe) |-> end_tok);

    assert_end_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_tok |=> !end_tok);

    assert_empty_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && word_count == '0) |=> (end_tok && !xmit_oe && !mem_rd_en));

    assert_busy_token_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state != ST_IDLE && start_tok) |=> (cur_state != ST_FETCH));
endmodule

bind rdchain_node rdchain_node_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_tok   (start_tok),
    .word_count  (word_count),
    .cur_state   (cur_state),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .ser_data    (ser_data),
    .xmit_flag   (xmit_flag),
    .xmit_oe     (xmit_oe),
    .end_tok     (end_tok)
);

// File: tb/rdchain_node_bench.sv
`timescale 1ns/1ps
module rdchain_node_bench;
    localparam int W  = 8;
    localparam int AW = 4;
    localparam int NCHIP = 3;
    localparam int NVEC = 6;
    localparam int VEC [NVEC][NCHIP] = '{
        '{3, 2, 1}, '{0, 4, 0}, '{1, 0, 2}, '{0, 0, 0}, '{16, 1, 5}, '{2, 16, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok = 1'b0;
    logic [AW:0] cnt [NCHIP];
    logic [NCHIP-1:0] start_v, end_v, rd_en_v, d_v, doe_v, x_v, xoe_v;
    logic [AW-1:0] addr [NCHIP];

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [W-1:0] word_of(input int g, input int i);
        return W'((g * 53 + i * 29 + 7) % 256);
    endfunction

    assign start_v = {end_v[NCHIP-2:0], tok};

    for (genvar g = 0; g < NCHIP; g++) begin : g_chip
        logic [W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (rd_en_v[g]) rd_q <= word_of(g, int'(addr[g]));
        end
        rdchain_node #(.WORD_W(W), .ADDR_W(AW)) u_rdchain_node (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_tok   (start_v[g]),
            .word_count  (cnt[g]),
            .mem_rd_en   (rd_en_v[g]),
            .mem_rd_addr (addr[g]),
            .mem_rd_data (rd_q),
            .ser_data    (d_v[g]),
            .ser_data_oe (doe_v[g]),
            .xmit_flag   (x_v[g]),
            .xmit_oe     (xoe_v[g]),
            .end_tok     (end_v[g])
        );
    end

    // bus monitor
    bit got_bits [512];
    int got_len, x0_cnt, x0_first, x0_last, end0_cnt, end0_cyc, end2_cyc, rd0_cnt;
    bit contend, leak, end2_seen, rd0_bad, mon_on;

    always @(negedge clk) begin
        if (mon_on) begin
            if ($countones(doe_v) > 1 || $countones(xoe_v) > 1) contend = 1'b1;
            for (int g = 0; g < NCHIP; g++)
                if (!xoe_v[g] && (x_v[g] || d_v[g])) leak = 1'b1;
            if (|(x_v & xoe_v) && got_len < 512) begin
                got_bits[got_len] = |(d_v & doe_v);
                got_len++;
            end
            if (x_v[0]) begin
                if (x0_cnt == 0) x0_first = cyc;
                x0_last = cyc;
                x0_cnt++;
            end
            if (end_v[0]) begin end0_cnt++; end0_cyc = cyc; end
            if (end_v[2]) begin end2_seen = 1'b1; end2_cyc = cyc; end
            if (rd_en_v[0]) begin
                if (int'(addr[0]) != rd0_cnt) rd0_bad = 1'b1;
                rd0_cnt++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    bit last_stream_ok;

    task automatic run_chain(input int n0, input int n1, input int n2,
                             input int tok_at, input int cnt_at, input int alt);
        int nn [NCHIP];
        bit exp_bits [512];
        int exp_len, s, e, e0, mism, guard, k;
        nn[0] = n0; nn[1] = n1; nn[2] = n2;
        exp_len = 0;
        for (int g = 0; g < NCHIP; g++)
            for (int i = 0; i < nn[g]; i++)
                for (int b = W - 1; b >= 0; b--) begin
                    exp_bits[exp_len] = word_of(g, i)[b];
                    exp_len++;
                end
        @(negedge clk);
        mon_on = 1'b0;
        for (int g = 0; g < NCHIP; g++) cnt[g] = (AW+1)'(nn[g]);
        got_len = 0; x0_cnt = 0; x0_first = 0; x0_last = 0; end0_cnt = 0;
        end0_cyc = 0; end2_cyc = 0; rd0_cnt = 0;
        contend = 0; leak = 0; end2_seen = 0; rd0_bad = 0;
        @(negedge clk);
        tok = 1'b1; mon_on = 1'b1; s = cyc;
        guard = 0;
        while (!end2_seen && guard < 3000) begin
            @(negedge clk);
            k = cyc - s;
            tok = (tok_at > 0 && k == tok_at);
            if (cnt_at > 0 && k == cnt_at) cnt[0] = (AW+1)'(alt);
            guard++;
        end
        repeat (3) @(negedge clk);
        mon_on = 1'b0;
        chk(end2_seen, "R11 chain end token seen", end2_seen, 1);
        e = s;
        e0 = s;
        for (int g = 0; g < NCHIP; g++) begin
            e = e + ((nn[g] > 0) ? (3 + nn[g] * W) : 1);
            if (g == 0) e0 = e;
        end
        chk(end2_cyc == e, "R11 last chip end cycle", end2_cyc - s, e - s);
        chk(!contend, "R2 shared line contention", contend, 0);
        chk(!leak, "R2 released chip drives line", leak, 0);
        mism = 0;
        for (int i = 0; i < exp_len && i < got_len; i++)
            if (got_bits[i] != exp_bits[i]) mism++;
        chk(got_len == exp_len, "R4 stream length", got_len, exp_len);
        chk(mism == 0, "R4 stream bit mismatches", mism, 0);
        last_stream_ok = (got_len == exp_len) && (mism == 0);
        chk(end0_cnt == 1 && end0_cyc == e0, "R6 chip0 end token cycle", end0_cyc - s, e0 - s);
        chk(rd0_cnt == n0 && !rd0_bad, "R10 chip0 read count and order", rd0_cnt, n0);
        if (n0 > 0) begin
            chk(x0_first == s + 3, "R3 first bit cycle", x0_first - s, 3);
            chk(x0_cnt == n0 * W && x0_last - x0_first + 1 == x0_cnt,
                "R5 flag run length", x0_cnt, n0 * W);
        end else begin
            chk(end0_cyc == s + 1 && x0_cnt == 0, "R7 empty chip end timing", end0_cyc - s, 1);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int g = 0; g < NCHIP; g++) cnt[g] = '0;
        mon_on = 1'b0;
        repeat (4) @(negedge clk);
        // R1: quiet during reset
        chk((doe_v | xoe_v | x_v | d_v | end_v | rd_en_v) == '0, "R1 outputs quiet in reset",
            longint'(doe_v | xoe_v | end_v | rd_en_v), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < NVEC; v++)
            run_chain(VEC[v][0], VEC[v][1], VEC[v][2], 0, 0, 0);

        // R8: token re-pulsed during chip0 stream
        run_chain(4, 1, 0, 10, 0, 0);
        chk(last_stream_ok && end0_cnt == 1, "R8 busy token ignored", end0_cnt, 1);

        // R9: count changed during readout
        run_chain(3, 2, 0, 0, 5, 9);
        chk(last_stream_ok && rd0_cnt == 3, "R9 count change ignored", rd0_cnt, 3);

        // R1: reset asserted mid-readout
        @(negedge clk);
        cnt[0] = 5'd8; cnt[1] = 5'd0; cnt[2] = 5'd0;
        tok = 1'b1;
        @(negedge clk);
        tok = 1'b0;
        repeat (20) @(negedge clk);
        chk(xoe_v[0] == 1'b1, "R1 precondition chip0 streaming", xoe_v[0], 1);
        rst_n = 1'b0;
        #1;
        chk((doe_v | xoe_v | x_v | d_v | end_v | rd_en_v) == '0, "R1 quiet on mid-run reset",
            longint'(doe_v | xoe_v | end_v | rd_en_v), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_chain(1, 1, 1, 0, 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule